// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a data cache controller. It keeps a direct-mapped main array of 128-byte lines next to a small, fully associative victim buffer. When a read miss installs a new line, the line it displaces moves into the victim buffer instead of being dropped. A later access that finds its line in the victim buffer completes exactly as fast as a main-array hit. The found line and the line that was in the main array swap places in the same cycle.

The CPU port takes a request with a 40-bit physical byte address (word aligned), a write flag, eight byte enables and 64-bit write data. It gives a one-cycle response pulse one cycle after it accepts the request. Only read misses allocate. A write that misses is sent straight to memory as a byte-enabled word write. The input `wt_mode` selects the write policy at run time: write-back (0) or write-through (1). A single memory request is outstanding at any time, and the CPU port is not ready while a request is open.

The memory port moves whole lines. It carries line reads, full-line write-backs and byte-masked word writes. Each request holds until an acknowledge arrives. The main array capacity `CACHE_BYTES` is a parameter from 8192 to 32768 bytes and a power of two. The victim depth `VB_ENTRIES` is 16 by default and a power of two.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1, `cpu_rvalid` is 0 and `mem_req` is 0. Every line is invalid, so the first read of any address is a miss.
- R2: An access that hits the main array is answered by `cpu_rvalid` one cycle after acceptance, with `cpu_ready` still high in that cycle. A read returns the most recently written value of that word.
- R3: An access that misses the main array but hits the victim buffer has the same latency as R2. The victim line and the displaced main-array line swap places, and each keeps its dirty bit.
- R4: A read miss issues one line read (`mem_op` = 0) at the line address `cpu_addr[39:7]`. When the acknowledge arrives, the returned word is answered on the next cycle and the line is installed clean in the main array.
- R5: A write miss does not allocate. It issues one word write (`mem_op` = 2) whose `mem_be` covers byte lanes 8*w to 8*w+7 of the line, where w = `cpu_addr[6:3]`. A following read of that line is a miss.
- R6: On a fill, a valid main-array line moves into the victim buffer. The first free entry is used, counted from entry 0. No line is ever held in two places.
- R7: When the victim buffer is full, entries are replaced in round-robin order starting at entry 0. A dirty entry is first written back as a full line write (`mem_op` = 1). A clean entry is overwritten without any memory traffic.
- R8: In write-back mode, a write hit marks the line dirty and creates no memory traffic.
- R9: In write-through mode, a write hit updates the cache and also issues a word write to memory with the CPU byte enables. The line is not marked dirty.
- R10: While `mem_req` is high, `cpu_ready` is low. `mem_op` and `mem_addr` stay stable until `mem_ack` is seen. A write-back is followed directly by the line read for the same miss.
- R11: Only the bytes whose `cpu_be` bit is set are changed by a write. Bit b of `cpu_be` covers `cpu_wdata[8b+7:8b]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_mode | input | 1 | 1 selects write-through, 0 selects write-back |
| cpu_req | input | 1 | CPU request valid |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 40 | Physical byte address, word aligned |
| cpu_be | input | 8 | Byte enables for writes |
| cpu_wdata | input | 64 | Write data |
| cpu_ready | output | 1 | Controller can accept a request this cycle |
| cpu_rvalid | output | 1 | Response pulse, one cycle |
| cpu_rdata | output | 64 | Read data, valid with `cpu_rvalid` on reads |
| mem_req | output | 1 | Memory request open |
| mem_op | output | 2 | 0 line read, 1 line write, 2 word write |
| mem_addr | output | 33 | Line address |
| mem_be | output | 128 | Byte mask for writes |
| mem_wdata | output | 1024 | Line-wide write data |
| mem_ack | input | 1 | Memory accepts or completes the open request |
| mem_rdata | input | 1024 | Line data, valid with `mem_ack` on line reads |

## Verification
The assertions assume that `cpu_addr` is always word aligned. They also assume the memory side raises `mem_ack` only while `mem_req` is high, and that on a line read the line data arrives with that acknowledge. The bench builds every address from a line number and a word number, so the low three bits are always zero. Its memory model answers only an open request, after a fixed delay, and drops the acknowledge on the following cycle. Requests are driven only while `cpu_ready` is high, so nothing is offered while a miss is in flight.

// File: rtl/dvc_pkg.sv
package dvc_pkg;
  localparam int ADDR_W     = 40;
  localparam int WORD_BYTES = 8;
  localparam int LINE_BYTES = 128;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WS_LO      = $clog2(WORD_BYTES);
  localparam int WS_W       = OFF_W - WS_LO;
  localparam int LADDR_W    = ADDR_W - OFF_W;

  typedef logic [LINE_W-1:0]  line_t;
  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [LADDR_W-1:0] laddr_t;

  typedef enum logic [1:0] {
    MOP_LINE_RD = 2'd0,
    MOP_LINE_WR = 2'd1,
    MOP_WORD_WR = 2'd2
  } mop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_POST
  } st_e;

  // Byte-masked write of one word into a line.
  function automatic line_t put_word(input line_t ln, input logic [WS_W-1:0] ws,
                                     input logic [WORD_BYTES-1:0] be, input word_t d);
    line_t r;
    r = ln;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (be[b]) r[int'(ws)*WORD_W + b*8 +: 8] = d[b*8 +: 8];
    end
    return r;
  endfunction

  function automatic word_t get_word(input line_t ln, input logic [WS_W-1:0] ws);
    return ln[int'(ws)*WORD_W +: WORD_W];
  endfunction

  // Line-wide byte mask for one word's lanes.
  function automatic logic [LINE_BYTES-1:0] lane_mask(input logic [WS_W-1:0] ws,
                                                      input logic [WORD_BYTES-1:0] be);
    logic [LINE_BYTES-1:0] r;
    r = '0;
    r[int'(ws)*WORD_BYTES +: WORD_BYTES] = be;
    return r;
  endfunction
endpackage

// File: rtl/dvc_main_array.sv
module dvc_main_array
  import dvc_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] rd_idx,
  output logic                    rd_valid,
  output logic                    rd_dirty,
  output logic [TAG_W-1:0]        rd_tag,
  output line_t                   rd_line,
  input  logic                    wr_en,
  input  logic [$clog2(SETS)-1:0] wr_idx,
  input  logic                    wr_dirty,
  input  logic [TAG_W-1:0]        wr_tag,
  input  line_t                   wr_line
);
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_mem  [SETS];
  line_t            line_mem [SETS];

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_line  = line_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      line_mem[wr_idx] <= wr_line;
    end
  end
endmodule

// File: rtl/dvc_victim_buf.sv
module dvc_victim_buf
  import dvc_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  laddr_t            lk_laddr,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic              hit_dirty,
  output line_t             hit_line,
  output logic [ENTRIES-1:0] match,
  output logic              has_free,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic              alloc_dirty,
  output laddr_t            alloc_laddr,
  output line_t             alloc_line,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  laddr_t            wr_laddr,
  input  line_t             wr_line,
  input  logic              adv
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;
  laddr_t             laddr_mem [ENTRIES];
  line_t              line_mem  [ENTRIES];
  logic [SLOT_W-1:0]  rr_q;
  logic [SLOT_W-1:0]  free_slot;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (laddr_mem[g] == lk_laddr);
  end

  // Lowest matching entry and lowest free entry.
  always_comb begin
    hit_slot  = '0;
    free_slot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i])    hit_slot  = SLOT_W'(i);
      if (!valid_q[i]) free_slot = SLOT_W'(i);
    end
  end

  assign hit         = |match;
  assign hit_dirty   = dirty_q[hit_slot];
  assign hit_line    = line_mem[hit_slot];
  assign has_free    = ~&valid_q;
  assign alloc_slot  = has_free ? free_slot : rr_q;
  assign alloc_dirty = valid_q[alloc_slot] && dirty_q[alloc_slot];
  assign alloc_laddr = laddr_mem[alloc_slot];
  assign alloc_line  = line_mem[alloc_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      rr_q    <= '0;
    end else begin
      if (wr_en) begin
        valid_q[wr_slot] <= wr_valid;
        dirty_q[wr_slot] <= wr_valid && wr_dirty;
      end
      if (adv) rr_q <= (int'(rr_q) == ENTRIES - 1) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      laddr_mem[wr_slot] <= wr_laddr;
      line_mem[wr_slot]  <= wr_line;
    end
  end
endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache
  import dvc_pkg::*;
#(
  parameter int CACHE_BYTES = 8192,
  parameter int VB_ENTRIES  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wt_mode,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [WORD_BYTES-1:0] cpu_be,
  input  logic [WORD_W-1:0]     cpu_wdata,
  output logic                  cpu_ready,
  output logic                  cpu_rvalid,
  output logic [WORD_W-1:0]     cpu_rdata,
  output logic                  mem_req,
  output logic [1:0]            mem_op,
  output logic [LADDR_W-1:0]    mem_addr,
  output logic [LINE_BYTES-1:0] mem_be,
  output logic [LINE_W-1:0]     mem_wdata,
  input  logic                  mem_ack,
  input  logic [LINE_W-1:0]     mem_rdata
);
  localparam int SETS   = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = LADDR_W - IDX_W;
  localparam int SLOT_W = $clog2(VB_ENTRIES);

  st_e                   st_q;
  laddr_t                rq_laddr;
  logic [WS_W-1:0]       rq_ws;
  logic [WORD_BYTES-1:0] rq_be;
  word_t                 rq_wdata;
  logic                  rvalid_q;
  word_t                 rdata_q;

  laddr_t            in_laddr, look_laddr;
  logic [WS_W-1:0]   in_ws;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;

  logic              m_valid, m_dirty;
  logic [TAG_W-1:0]  m_tag;
  line_t             m_line;
  logic              m_we, m_wdirty;
  line_t             m_wline;

  logic                  v_hit, v_hit_dirty, v_has_free, v_alloc_dirty;
  logic [SLOT_W-1:0]     v_hit_slot, v_alloc_slot, v_wslot;
  logic [VB_ENTRIES-1:0] vb_match;
  line_t                 v_hit_line, v_alloc_line;
  laddr_t                v_alloc_laddr;
  logic                  v_we, v_wvalid, v_wdirty, v_adv;

  // Named events used by the checker.
  logic main_hit_raw, ev_accept, ev_main_hit, ev_vic_hit, ev_miss;
  logic ev_fill_done, ev_wb_done, ev_post_done, need_wb;
  mop_e mop;

  assign in_laddr   = cpu_addr[ADDR_W-1:OFF_W];
  assign in_ws      = cpu_addr[OFF_W-1:WS_LO];
  assign look_laddr = (st_q == ST_IDLE) ? in_laddr : rq_laddr;
  assign look_idx   = look_laddr[IDX_W-1:0];
  assign look_tag   = look_laddr[LADDR_W-1:IDX_W];

  dvc_main_array #(.SETS(SETS), .TAG_W(TAG_W)) u_main (
    .clk(clk), .rst_n(rst_n), .rd_idx(look_idx),
    .rd_valid(m_valid), .rd_dirty(m_dirty), .rd_tag(m_tag), .rd_line(m_line),
    .wr_en(m_we), .wr_idx(look_idx), .wr_dirty(m_wdirty), .wr_tag(look_tag),
    .wr_line(m_wline)
  );

  dvc_victim_buf #(.ENTRIES(VB_ENTRIES)) u_vict (
    .clk(clk), .rst_n(rst_n), .lk_laddr(look_laddr),
    .hit(v_hit), .hit_slot(v_hit_slot), .hit_dirty(v_hit_dirty), .hit_line(v_hit_line),
    .match(vb_match), .has_free(v_has_free), .alloc_slot(v_alloc_slot),
    .alloc_dirty(v_alloc_dirty), .alloc_laddr(v_alloc_laddr), .alloc_line(v_alloc_line),
    .wr_en(v_we), .wr_slot(v_wslot), .wr_valid(v_wvalid), .wr_dirty(v_wdirty),
    .wr_laddr({m_tag, look_idx}), .wr_line(m_line), .adv(v_adv)
  );

  assign main_hit_raw = m_valid && (m_tag == look_tag);
  assign cpu_ready    = (st_q == ST_IDLE);
  assign ev_accept    = cpu_req && cpu_ready;
  assign ev_main_hit  = ev_accept && main_hit_raw;
  assign ev_vic_hit   = ev_accept && !main_hit_raw && v_hit;
  assign ev_miss      = ev_accept && !main_hit_raw && !v_hit;
  assign ev_fill_done = (st_q == ST_FILL)  && mem_ack;
  assign ev_wb_done   = (st_q == ST_WBACK) && mem_ack;
  assign ev_post_done = (st_q == ST_POST)  && mem_ack;
  assign need_wb      = m_valid && !v_has_free && v_alloc_dirty;

  // Memory request side
  always_comb begin
    mop       = MOP_LINE_RD;
    mem_addr  = rq_laddr;
    mem_wdata = '0;
    mem_be    = '0;
    case (st_q)
      ST_WBACK: begin
        mop       = MOP_LINE_WR;
        mem_addr  = v_alloc_laddr;
        mem_wdata = v_alloc_line;
        mem_be    = '1;
      end
      ST_POST: begin
        mop       = MOP_WORD_WR;
        mem_wdata = put_word('0, rq_ws, rq_be, rq_wdata);
        mem_be    = lane_mask(rq_ws, rq_be);
      end
      default: ;
    endcase
  end
  assign mem_req = (st_q != ST_IDLE);
  assign mem_op  = mop;

  // Main array update
  always_comb begin
    m_we    = 1'b0;
    m_wdirty = 1'b0;
    m_wline = m_line;
    if (ev_main_hit && cpu_we) begin
      m_we     = 1'b1;
      m_wdirty = m_dirty || !wt_mode;
      m_wline  = put_word(m_line, in_ws, cpu_be, cpu_wdata);
    end else if (ev_vic_hit) begin
      m_we     = 1'b1;
      m_wdirty = v_hit_dirty || (cpu_we && !wt_mode);
      m_wline  = cpu_we ? put_word(v_hit_line, in_ws, cpu_be, cpu_wdata) : v_hit_line;
    end else if (ev_fill_done) begin
      m_we     = 1'b1;
      m_wdirty = 1'b0;
      m_wline  = mem_rdata;
    end
  end

  // Victim buffer update: swap target or eviction target
  always_comb begin
    v_we     = 1'b0;
    v_wslot  = v_alloc_slot;
    v_wvalid = m_valid;
    v_wdirty = m_dirty;
    v_adv    = 1'b0;
    if (ev_vic_hit) begin
      v_we    = 1'b1;
      v_wslot = v_hit_slot;
    end else if (ev_fill_done && m_valid) begin
      v_we  = 1'b1;
      v_adv = !v_has_free;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rq_laddr <= '0;
      rq_ws    <= '0;
      rq_be    <= '0;
      rq_wdata <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= (ev_accept && !(ev_miss && !cpu_we)) || ev_fill_done;
      if (ev_accept) begin
        rq_laddr <= in_laddr;
        rq_ws    <= in_ws;
        rq_be    <= cpu_be;
        rq_wdata <= cpu_wdata;
      end
      if (ev_main_hit && !cpu_we)     rdata_q <= get_word(m_line, in_ws);
      else if (ev_vic_hit && !cpu_we) rdata_q <= get_word(v_hit_line, in_ws);
      else if (ev_fill_done)          rdata_q <= get_word(mem_rdata, rq_ws);
      case (st_q)
        ST_IDLE: begin
          if (ev_miss && cpu_we)       st_q <= ST_POST;
          else if (ev_miss)            st_q <= need_wb ? ST_WBACK : ST_FILL;
          else if (ev_accept && cpu_we && wt_mode) st_q <= ST_POST;
        end
        ST_WBACK: if (ev_wb_done)   st_q <= ST_FILL;
        ST_FILL:  if (ev_fill_done) st_q <= ST_IDLE;
        ST_POST:  if (ev_post_done) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;
endmodule

// File: rtl/dvc_checker.sv
module dvc_checker #(
  parameter int VB_ENTRIES = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wt_mode,
  input logic                  cpu_req,
  input logic                  cpu_we,
  input logic [2:0]            cpu_addr_lo,
  input logic                  cpu_ready,
  input logic                  cpu_rvalid,
  input logic                  mem_req,
  input logic [1:0]            mem_op,
  input logic [32:0]           mem_addr,
  input logic                  mem_ack,
  input logic                  ev_accept,
  input logic                  main_hit_raw,
  input logic                  v_hit,
  input logic [VB_ENTRIES-1:0] vb_match
);
  // Input assumption: word-aligned requests
  p_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> cpu_addr_lo == 3'd0);

  p_main_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && main_hit_raw && !cpu_we |=> cpu_rvalid && cpu_ready);

  p_vict_same_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !main_hit_raw && v_hit && !(cpu_we && wt_mode) |=> cpu_rvalid && cpu_ready);

  p_read_miss_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !main_hit_raw && !v_hit && !cpu_we |=>
      mem_req && (mem_op == 2'd0 || mem_op == 2'd1) && !cpu_rvalid);

  p_fill_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_op == 2'd0 |=> cpu_rvalid && cpu_ready);

  p_write_miss_post_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !main_hit_raw && !v_hit && cpu_we |=> mem_req && mem_op == 2'd2 && cpu_rvalid);

  p_single_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vb_match) && !(main_hit_raw && v_hit));

  p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_op == 2'd1 |=> mem_req && mem_op == 2'd0);

  p_wb_hit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && (main_hit_raw || v_hit) && cpu_we && !wt_mode |=> !mem_req);

  p_wt_hit_post_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && (main_hit_raw || v_hit) && cpu_we && wt_mode |=> mem_req && mem_op == 2'd2);

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_op) && $stable(mem_addr));
endmodule

bind dm_victim_cache dvc_checker #(.VB_ENTRIES(VB_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr_lo(cpu_addr[2:0]), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
  .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .ev_accept(ev_accept), .main_hit_raw(main_hit_raw), .v_hit(v_hit), .vb_match(vb_match)
);

// File: tb/dm_victim_cache_tb_top.sv
module dm_victim_cache_tb_top;
  localparam int MLINES = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wt_mode = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [39:0]   cpu_addr = '0;
  logic [7:0]    cpu_be = '0;
  logic [63:0]   cpu_wdata = '0;
  logic          cpu_ready, cpu_rvalid;
  logic [63:0]   cpu_rdata;
  logic          mem_req;
  logic [1:0]    mem_op;
  logic [32:0]   mem_addr;
  logic [127:0]  mem_be;
  logic [1023:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [1023:0] mem_rdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  dm_victim_cache dut_i (
    .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_op(mem_op),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  logic [1023:0] mem  [MLINES];
  logic [1023:0] gold [MLINES];
  int checks = 0, fails = 0, cyc = 0;
  int n_line_rd = 0, n_line_wr = 0, n_word_wr = 0, dly = 0;

  function automatic logic [63:0] init_word(int line, int w);
    return {32'(line) ^ 32'h5A5A_0000, 32'(w) ^ 32'h0000_C3C3};
  endfunction

  function automatic logic [63:0] word_of(logic [1023:0] ln, int w);
    return ln[w*64 +: 64];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: ack after a fixed delay, drop it the next cycle.
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      dly = 0;
    end else if (mem_req) begin
      if (dly == 2) begin
        case (mem_op)
          2'd0: begin mem_rdata = mem[mem_addr[10:0]]; n_line_rd++; end
          default: begin
            for (int b = 0; b < 128; b++)
              if (mem_be[b]) mem[mem_addr[10:0]][b*8 +: 8] = mem_wdata[b*8 +: 8];
            if (mem_op == 2'd1) n_line_wr++; else n_word_wr++;
          end
        endcase
        mem_ack = 1'b1;
      end else dly++;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // One CPU access; starts and ends at a falling edge.
  task automatic access(input logic we, input int line, input int w, input logic [7:0] be,
                        input logic [63:0] d, output int lat, output logic stalled,
                        output logic [63:0] rd);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_wdata = d;
    cpu_addr = {7'd0, 26'(line), 4'(w), 3'd0};
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    stalled = !cpu_ready;
    lat = 1;
    while (!cpu_rvalid) begin @(negedge clk); lat++; end
    rd = cpu_rdata;
    if (we)
      for (int b = 0; b < 8; b++)
        if (be[b]) gold[line][w*64 + b*8 +: 8] = d[b*8 +: 8];
  endtask

  typedef struct packed {
    logic        we;
    logic [11:0] line;
    logic [3:0]  word;
    logic [7:0]  be;
    logic [63:0] data;
    logic        fast;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'd3,   4'd0, 8'hFF, 64'h0,                   1'b0}, // R1 R4 cold miss
    '{1'b0, 12'd3,   4'd1, 8'hFF, 64'h0,                   1'b1}, // R2 main hit
    '{1'b1, 12'd3,   4'd2, 8'hFF, 64'h1111_2222_3333_4444, 1'b1}, // R8 write hit
    '{1'b0, 12'd67,  4'd0, 8'hFF, 64'h0,                   1'b0}, // R6 conflict miss
    '{1'b0, 12'd3,   4'd2, 8'hFF, 64'h0,                   1'b1}, // R3 victim read
    '{1'b0, 12'd67,  4'd5, 8'hFF, 64'h0,                   1'b1}, // R3 swap back
    '{1'b1, 12'd3,   4'd4, 8'hFF, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1}, // R3 victim write
    '{1'b0, 12'd3,   4'd4, 8'hFF, 64'h0,                   1'b1}, // R2 after swap
    '{1'b1, 12'd3,   4'd1, 8'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1}, // R11 partial write
    '{1'b0, 12'd3,   4'd1, 8'hFF, 64'h0,                   1'b1}, // R11 merged read
    '{1'b1, 12'd200, 4'd0, 8'hFF, 64'h0123_4567_89AB_CDEF, 1'b0}, // R5 write miss
    '{1'b0, 12'd200, 4'd0, 8'hFF, 64'h0,                   1'b0}, // R5 no allocation
    '{1'b0, 12'd67,  4'd5, 8'hFF, 64'h0,                   1'b1}  // R3 victim hit
  };

  initial begin
    int lat;
    logic st;
    logic [63:0] rd;
    int base_wr, base_all;
    for (int l = 0; l < MLINES; l++)
      for (int w = 0; w < 16; w++) begin
        mem[l][w*64 +: 64]  = init_word(l, w);
        gold[l][w*64 +: 64] = init_word(l, w);
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(cpu_ready == 1'b1, "R1 ready after reset", 64'(cpu_ready), 64'd1);
    chk(mem_req == 1'b0, "R1 no memory request", 64'(mem_req), 64'd0);
    chk(cpu_rvalid == 1'b0, "R1 no response", 64'(cpu_rvalid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].we, int'(VEC[i].line), int'(VEC[i].word), VEC[i].be, VEC[i].data, lat, st, rd);
      if (VEC[i].fast)
        chk(lat == 1 && !st, $sformatf("R2/R3 vector %0d single-cycle", i), 64'(lat), 64'd1);
      else
        chk(st, $sformatf("R10 vector %0d stalls port", i), 64'(st), 64'd1);
      if (!VEC[i].we)
        chk(rd == word_of(gold[VEC[i].line], int'(VEC[i].word)),
            $sformatf("R2/R4 vector %0d read data", i), rd, word_of(gold[VEC[i].line], int'(VEC[i].word)));
    end
    chk(word_of(mem[200], 0) == 64'h0123_4567_89AB_CDEF, "R5 posted word in memory",
        word_of(mem[200], 0), 64'h0123_4567_89AB_CDEF);

    // R8: write hit in write-back mode, no memory traffic (line 67 is in main)
    base_all = n_line_rd + n_line_wr + n_word_wr;
    access(1'b1, 67, 6, 8'hFF, 64'hDEAD_0000_BEEF_0001, lat, st, rd);
    chk(lat == 1 && !st, "R8 write hit single-cycle", 64'(lat), 64'd1);
    @(negedge clk);
    chk(n_line_rd + n_line_wr + n_word_wr == base_all, "R8 no memory traffic",
        64'(n_line_rd + n_line_wr + n_word_wr), 64'(base_all));

    // R6/R7: chain of conflicting lines at index 10 fills the victim buffer
    access(1'b0, 10, 0, 8'hFF, 64'h0, lat, st, rd);
    access(1'b1, 10, 0, 8'hFF, 64'hD1D1_D2D2_D3D3_D4D4, lat, st, rd);
    for (int k = 1; k <= 15; k++) access(1'b0, 10 + 64*k, 0, 8'hFF, 64'h0, lat, st, rd);
    base_wr = n_line_wr;
    access(1'b0, 10 + 64*16, 0, 8'hFF, 64'h0, lat, st, rd);
    chk(n_line_wr == base_wr + 1, "R7 first full eviction writes back entry 0",
        64'(n_line_wr), 64'(base_wr + 1));
    chk(word_of(mem[3], 2) == 64'h1111_2222_3333_4444, "R7 dirty line 3 reached memory",
        word_of(mem[3], 2), 64'h1111_2222_3333_4444);
    chk(word_of(mem[10], 0) == init_word(10, 0), "R7 line 10 still held dirty",
        word_of(mem[10], 0), init_word(10, 0));
    access(1'b0, 10 + 64*17, 0, 8'hFF, 64'h0, lat, st, rd);
    chk(n_line_wr == base_wr + 2, "R7 round-robin reaches entry 1",
        64'(n_line_wr), 64'(base_wr + 2));
    chk(word_of(mem[10], 0) == 64'hD1D1_D2D2_D3D3_D4D4, "R7 line 10 written back",
        word_of(mem[10], 0), 64'hD1D1_D2D2_D3D3_D4D4);
    access(1'b0, 10, 0, 8'hFF, 64'h0, lat, st, rd);
    chk(rd == 64'hD1D1_D2D2_D3D3_D4D4, "R4 refetch after write-back", rd, 64'hD1D1_D2D2_D3D3_D4D4);
    chk(n_line_wr == base_wr + 2, "R7 clean entry dropped silently",
        64'(n_line_wr), 64'(base_wr + 2));
    access(1'b0, 10 + 64*2, 3, 8'hFF, 64'h0, lat, st, rd);
    chk(lat == 1 && !st, "R3 victim hit after replacements", 64'(lat), 64'd1);
    chk(rd == init_word(138, 3), "R6 victim line data kept", rd, init_word(138, 3));

    // R9: write-through write hit
    @(negedge clk);
    wt_mode = 1'b1;
    access(1'b0, 500, 0, 8'hFF, 64'h0, lat, st, rd);
    base_all = n_word_wr;
    access(1'b1, 500, 3, 8'hF0, 64'h7777_6666_5555_4444, lat, st, rd);
    chk(st, "R9 write-through occupies port", 64'(st), 64'd1);
    while (!cpu_ready) @(negedge clk);
    chk(n_word_wr == base_all + 1, "R9 one word write", 64'(n_word_wr), 64'(base_all + 1));
    chk(word_of(mem[500], 3) == word_of(gold[500], 3), "R9 R11 memory masked update",
        word_of(mem[500], 3), word_of(gold[500], 3));
    access(1'b0, 500, 3, 8'hFF, 64'h0, lat, st, rd);
    chk(rd == word_of(gold[500], 3), "R9 cache copy updated", rd, word_of(gold[500], 3));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule